// File: doc/BRIEF.md
# Streaming Sensor Threshold Filter

This block sits in line on the receive path between the network and the host. It takes packets as a stream of bus-wide flits, one flit per cycle. On the first flit of each UDP packet it reads an unsigned sensor reading and compares it with a programmable threshold. A reading above the threshold is an anomaly, and the whole packet goes to the host. Any other reading marks the packet as normal, and the whole packet is discarded before it reaches the host. Packets that are not UDP pass through unchanged and are not inspected.

Each inspected reading also updates three saturating statistics: how many readings arrived, their running sum (the host divides the sum by the count to get the average), and how many were anomalies. A separate command port, off the data path, sets the threshold, reads the threshold and the statistics, and clears the statistics. One output register gives the host side backpressure. When the host stalls, the input stalls too, so no flit is lost.

Top module: `anomaly_gate`

## Requirements
- R1: After reset `out_valid_o` is 0 and `in_ready_o` is 1. The threshold reads back as `THR_RST`, and the reading count, the sum and the alert count all read 0.
- R2: The first accepted flit after reset is a first flit. So is the first accepted flit after every accepted flit with `in_last_i`=1.
- R3: A first flit is UDP when bits [PROTO_LSB+7:PROTO_LSB] equal 17. Its reading is the unsigned field at bits [READ_LSB+READ_W-1:READ_LSB]. When reading > threshold, every flit of the packet is forwarded unchanged and in order, with its last flag. When reading <= threshold, every flit of the packet is dropped.
- R4: A packet whose first flit is not UDP is forwarded unchanged, and it leaves all statistics unchanged.
- R5: The pass/drop decision taken on the first flit holds for every later flit of the same packet, even if the threshold changes mid-packet.
- R6: A forwarded flit appears on the output in the cycle after it is accepted. While `out_valid_o`=1 and `out_ready_i`=0, the output stays stable and `in_ready_o` is 0. A held flit is never lost.
- R7: Each UDP first flit adds 1 to the reading count and adds its reading to the sum. It also adds 1 to the alert count when reading > threshold.
- R8: Each statistic saturates at all ones instead of wrapping.
- R9: The command op is encoded 0 no-op, 1 set threshold (from `cmd_wdata_i`), 2 read, 3 clear statistics. A read returns `rsp_valid_o`=1 with the data one cycle later. The read selector is 0 threshold, 1 count, 2 sum, 3 alert count, zero-extended. Other ops produce no response.
- R10: A clear command in the same cycle as a statistics update leaves all statistics at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input flit valid |
| in_ready_o | output | 1 | Input flit accepted when high with valid |
| in_data_i | input | DATA_W | Input flit data |
| in_last_i | input | 1 | Input flit ends its packet |
| out_valid_o | output | 1 | Host-side flit valid |
| out_ready_i | input | 1 | Host side accepts a flit |
| out_data_o | output | DATA_W | Host-side flit data |
| out_last_o | output | 1 | Host-side flit ends its packet |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | Command op |
| cmd_sel_i | input | 2 | Register selector for reads |
| cmd_wdata_i | input | READ_W | New threshold value |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_data_o | output | SUM_W | Read response data |

## Verification
The assertions check on every cycle that a stalled output stays stable, that a flit marked last re-arms first-flit detection, that the reading count only falls on a clear, that the alert count never exceeds the reading count, that a clear empties the statistics, and that a read response appears exactly one cycle after a read command. Only the bench scenarios can show the pass/drop decision itself: sweeps of every 8-bit reading against several thresholds, the decision held across multi-flit packets while the threshold changes, non-UDP bypass, backpressure, saturation of every statistic, and a clear that collides with an update.

// File: rtl/anomaly_pkg.sv
`timescale 1ns/1ps
package anomaly_pkg;
  typedef enum logic [1:0] {
    OP_NOP     = 2'd0,
    OP_SET_THR = 2'd1,
    OP_READ    = 2'd2,
    OP_CLEAR   = 2'd3
  } cmd_op_e;

  typedef enum logic [1:0] {
    SEL_THR   = 2'd0,
    SEL_CNT   = 2'd1,
    SEL_SUM   = 2'd2,
    SEL_ALERT = 2'd3
  } reg_sel_e;

  localparam logic [7:0] PROTO_UDP = 8'd17;
endpackage

// File: rtl/flit_classify.sv
`timescale 1ns/1ps
module flit_classify #(
  parameter int unsigned READ_W = 16
) (
  input  logic [7:0]        proto_i,
  input  logic [READ_W-1:0] reading_i,
  input  logic [READ_W-1:0] thr_i,
  output logic              is_udp_o,
  output logic              above_o
);
  assign is_udp_o = (proto_i == anomaly_pkg::PROTO_UDP);
  assign above_o  = (reading_i > thr_i);
endmodule

// File: rtl/pkt_tracker.sv
`timescale 1ns/1ps
module pkt_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic beat_i,
  input  logic last_i,
  input  logic pass_now_i,
  output logic first_o,
  output logic keep_o
);
  logic first_q, pass_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b1;
      pass_q  <= 1'b0;
    end else if (beat_i) begin
      first_q <= last_i;
      if (first_q) pass_q <= pass_now_i;
    end
  end

  assign first_o = first_q;
  // first flit decides, later flits follow the latched decision
  assign keep_o  = first_q ? pass_now_i : pass_q;
endmodule

// File: rtl/sat_acc.sv
`timescale 1ns/1ps
module sat_acc #(
  parameter int unsigned W    = 32,
  parameter int unsigned IN_W = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            en_i,
  input  logic [IN_W-1:0] inc_i,
  output logic [W-1:0]    q_o
);
  localparam logic [W-1:0] MAX_V = '1;
  localparam int unsigned  PAD_W = W + 1 - IN_W;

  logic [W-1:0] q_q;
  logic [W:0]   sum;

  assign sum = {1'b0, q_q} + {{PAD_W{1'b0}}, inc_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '0;
    else if (clr_i)  q_q <= '0;
    else if (en_i)   q_q <= sum[W] ? MAX_V : sum[W-1:0];
  end

  assign q_o = q_q;
endmodule

// File: rtl/flit_reg.sv
`timescale 1ns/1ps
module flit_reg #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              last_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              last_o
);
  logic              valid_q, last_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      last_q  <= 1'b0;
    end else begin
      if (load_i)       valid_q <= 1'b1;
      else if (ready_i) valid_q <= 1'b0;
      if (load_i) begin
        data_q <= data_i;
        last_q <= last_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign last_o  = last_q;
endmodule

// File: rtl/ctrl_regs.sv
`timescale 1ns/1ps
module ctrl_regs #(
  parameter int unsigned READ_W  = 16,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned SUM_W   = 48,
  parameter int unsigned THR_RST = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [1:0]        cmd_sel_i,
  input  logic [READ_W-1:0] cmd_wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [SUM_W-1:0]  sum_i,
  input  logic [CNT_W-1:0]  alert_i,
  output logic [READ_W-1:0] thr_o,
  output logic              clr_o,
  output logic              rsp_valid_o,
  output logic [SUM_W-1:0]  rsp_data_o
);
  import anomaly_pkg::*;

  logic [READ_W-1:0] thr_q;
  logic              rsp_valid_q;
  logic [SUM_W-1:0]  rsp_data_q, rd_mux;
  logic              do_read;

  assign do_read = cmd_valid_i && (cmd_op_i == OP_READ);
  assign clr_o   = cmd_valid_i && (cmd_op_i == OP_CLEAR);

  always_comb begin
    unique case (cmd_sel_i)
      SEL_THR:   rd_mux = SUM_W'(thr_q);
      SEL_CNT:   rd_mux = SUM_W'(cnt_i);
      SEL_SUM:   rd_mux = sum_i;
      default:   rd_mux = SUM_W'(alert_i);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q       <= READ_W'(THR_RST);
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      if (cmd_valid_i && (cmd_op_i == OP_SET_THR)) thr_q <= cmd_wdata_i;
      rsp_valid_q <= do_read;
      if (do_read) rsp_data_q <= rd_mux;
    end
  end

  assign thr_o       = thr_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
endmodule

// File: rtl/anomaly_gate.sv
`timescale 1ns/1ps
module anomaly_gate #(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned READ_W    = 16,
  parameter int unsigned PROTO_LSB = 0,
  parameter int unsigned READ_LSB  = 16,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned SUM_W     = 48,
  parameter int unsigned THR_RST   = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_last_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_last_o,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [1:0]        cmd_sel_i,
  input  logic [READ_W-1:0] cmd_wdata_i,
  output logic              rsp_valid_o,
  output logic [SUM_W-1:0]  rsp_data_o
);
  logic [READ_W-1:0] thr, reading;
  logic              clr, is_udp, above, pass_now;
  logic              first_flit, keep, beat, stat_en;
  logic [CNT_W-1:0]  cnt_q, alert_q;
  logic [SUM_W-1:0]  sum_q;

  assign reading    = in_data_i[READ_LSB +: READ_W];
  assign in_ready_o = !out_valid_o || out_ready_i;
  assign beat       = in_valid_i && in_ready_o;
  assign pass_now   = !is_udp || above;
  assign stat_en    = beat && first_flit && is_udp;

  flit_classify #(.READ_W(READ_W)) u_cls (
    .proto_i   (in_data_i[PROTO_LSB +: 8]),
    .reading_i (reading),
    .thr_i     (thr),
    .is_udp_o  (is_udp),
    .above_o   (above)
  );

  pkt_tracker u_trk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .beat_i     (beat),
    .last_i     (in_last_i),
    .pass_now_i (pass_now),
    .first_o    (first_flit),
    .keep_o     (keep)
  );

  flit_reg #(.DATA_W(DATA_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (beat && keep),
    .data_i  (in_data_i),
    .last_i  (in_last_i),
    .ready_i (out_ready_i),
    .valid_o (out_valid_o),
    .data_o  (out_data_o),
    .last_o  (out_last_o)
  );

  sat_acc #(.W(CNT_W), .IN_W(1)) u_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (clr),
    .en_i  (stat_en), .inc_i (1'b1), .q_o (cnt_q)
  );

  sat_acc #(.W(SUM_W), .IN_W(READ_W)) u_sum (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (clr),
    .en_i  (stat_en), .inc_i (reading), .q_o (sum_q)
  );

  sat_acc #(.W(CNT_W), .IN_W(1)) u_alert (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (clr),
    .en_i  (stat_en && above), .inc_i (1'b1), .q_o (alert_q)
  );

  ctrl_regs #(
    .READ_W(READ_W), .CNT_W(CNT_W), .SUM_W(SUM_W), .THR_RST(THR_RST)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .cmd_sel_i   (cmd_sel_i),
    .cmd_wdata_i (cmd_wdata_i),
    .cnt_i       (cnt_q),
    .sum_i       (sum_q),
    .alert_i     (alert_q),
    .thr_o       (thr),
    .clr_o       (clr),
    .rsp_valid_o (rsp_valid_o),
    .rsp_data_o  (rsp_data_o)
  );
endmodule

// File: rtl/anomaly_gate_chk.sv
`timescale 1ns/1ps
module anomaly_gate_chk #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              in_last_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] out_data_o,
  input logic              cmd_valid_i,
  input logic [1:0]        cmd_op_i,
  input logic              rsp_valid_o,
  input logic              first_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  alert_i
);
  import anomaly_pkg::*;

  a_r6_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  a_r2_rearm_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && in_last_i |=> first_i);

  a_r8_cnt_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_i && cmd_op_i == OP_CLEAR) |=> cnt_i >= $past(cnt_i));

  a_r7_alert_le_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_i <= cnt_i);

  a_r10_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_op_i == OP_CLEAR |=> cnt_i == '0 && alert_i == '0);

  a_r9_rsp_follows_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_op_i == OP_READ |=> rsp_valid_o);

  a_r9_no_stray_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_i && cmd_op_i == OP_READ) |=> !rsp_valid_o);
endmodule

bind anomaly_gate anomaly_gate_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_last_i   (in_last_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .rsp_valid_o (rsp_valid_o),
  .first_i     (first_flit),
  .cnt_i       (cnt_q),
  .alert_i     (alert_q)
);

// File: tb/anomaly_gate_test.sv
`timescale 1ns/1ps
module anomaly_gate_test;
  import anomaly_pkg::*;

  localparam int CNT_MAX = 15;
  localparam int SUM_MAX = 1023;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic [15:0] in_data = '0;
  logic        in_ready, out_valid, out_last, rsp_valid;
  logic [15:0] out_data;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0, cmd_sel = '0;
  logic [7:0]  cmd_wdata = '0;
  logic [9:0]  rsp_data;

  int checks = 0, errors = 0;
  int m_cnt = 0, m_sum = 0, m_alert = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  anomaly_gate #(
    .DATA_W(16), .READ_W(8), .PROTO_LSB(0), .READ_LSB(8),
    .CNT_W(4), .SUM_W(10), .THR_RST(128)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data), .in_last_i(in_last),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data), .out_last_o(out_last),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_sel_i(cmd_sel), .cmd_wdata_i(cmd_wdata),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic beat(input logic [15:0] d, input logic last);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_last = last;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic cmd(input cmd_op_e op, input logic [1:0] sel, input logic [7:0] wd);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_sel = sel; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = OP_NOP;
  endtask

  task automatic rd(input logic [1:0] sel, output int v);
    cmd(OP_READ, sel, 8'd0);
    chk(rsp_valid == 1'b1, "R9 read response valid", int'(rsp_valid), 1);
    v = int'(rsp_data);
  endtask

  function automatic int sat(input int v, input int mx);
    return (v > mx) ? mx : v;
  endfunction

  function automatic void model_pkt(input int r, input int thr);
    m_cnt = sat(m_cnt + 1, CNT_MAX);
    m_sum = sat(m_sum + r, SUM_MAX);
    if (r > thr) m_alert = sat(m_alert + 1, CNT_MAX);
  endfunction

  task automatic check_stats(input string req);
    int v;
    rd(2'd1, v); chk(v == m_cnt,   {req, " reading count"}, v, m_cnt);
    rd(2'd2, v); chk(v == m_sum,   {req, " reading sum"},   v, m_sum);
    rd(2'd3, v); chk(v == m_alert, {req, " alert count"},   v, m_alert);
  endtask

  task automatic clear_all();
    cmd(OP_CLEAR, 2'd0, 8'd0);
    m_cnt = 0; m_sum = 0; m_alert = 0;
  endtask

  // one flit of a packet; exp_pass says whether it must reach the output
  task automatic flit_chk(input logic [15:0] d, input logic last, input bit exp_pass, input string req);
    beat(d, last);
    chk(out_valid == exp_pass, {req, " output valid"}, int'(out_valid), int'(exp_pass));
    if (exp_pass) begin
      chk(out_data == d, {req, " output data"}, int'(out_data), int'(d));
      chk(out_last == last, {req, " output last"}, int'(out_last), int'(last));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    int thr_list[3] = '{0, 128, 255};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    rd(2'd0, v); chk(v == 128, "R1 threshold reset", v, 128);
    check_stats("R1");

    // R9 threshold write then read back
    cmd(OP_SET_THR, 2'd0, 8'd77);
    rd(2'd0, v); chk(v == 77, "R9 threshold readback", v, 77);

    // R3 R7 R8 exhaustive reading sweep per threshold, single-flit packets
    foreach (thr_list[t]) begin
      cmd(OP_SET_THR, 2'd0, 8'(thr_list[t]));
      clear_all();
      for (int r = 0; r < 256; r++) begin
        flit_chk({8'(r), 8'd17}, 1'b1, r > thr_list[t], "R3 sweep");
        model_pkt(r, thr_list[t]);
      end
      check_stats("R8 sweep saturation");
    end

    // R7 exact statistics before saturation
    cmd(OP_SET_THR, 2'd0, 8'd128);
    clear_all();
    flit_chk({8'd10, 8'd17}, 1'b1, 1'b0, "R7 low");   model_pkt(10, 128);
    flit_chk({8'd200, 8'd17}, 1'b1, 1'b1, "R7 high"); model_pkt(200, 128);
    flit_chk({8'd130, 8'd17}, 1'b1, 1'b1, "R7 high"); model_pkt(130, 128);
    flit_chk({8'd128, 8'd17}, 1'b1, 1'b0, "R3 equal drops"); model_pkt(128, 128);
    check_stats("R7");

    // R3 multi-flit pass and drop; R2 each new packet re-decided
    flit_chk({8'h90, 8'd17}, 1'b0, 1'b1, "R3 multi pass first");
    flit_chk(16'hA5A5, 1'b0, 1'b1, "R3 multi pass mid");
    flit_chk(16'h3C11, 1'b1, 1'b1, "R3 multi pass last");
    model_pkt(144, 128);
    flit_chk({8'h20, 8'd17}, 1'b0, 1'b0, "R3 multi drop first");
    flit_chk({8'hFF, 8'd17}, 1'b0, 1'b0, "R2 mid flit not reparsed");
    flit_chk(16'h5A5A, 1'b1, 1'b0, "R3 multi drop last");
    model_pkt(32, 128);
    flit_chk({8'hC0, 8'd17}, 1'b1, 1'b1, "R2 next first decided");
    model_pkt(192, 128);
    check_stats("R2 R7 multi");

    // R5 decision held while threshold changes mid-packet
    flit_chk({8'h90, 8'd17}, 1'b0, 1'b1, "R5 pass first");
    model_pkt(144, 128);
    cmd(OP_SET_THR, 2'd0, 8'd255);
    flit_chk(16'h1234, 1'b0, 1'b1, "R5 pass held mid");
    flit_chk(16'h5678, 1'b1, 1'b1, "R5 pass held last");
    flit_chk({8'h90, 8'd17}, 1'b0, 1'b0, "R5 drop first");
    model_pkt(144, 255);
    cmd(OP_SET_THR, 2'd0, 8'd0);
    flit_chk(16'h9ABC, 1'b0, 1'b0, "R5 drop held mid");
    flit_chk(16'hDEF0, 1'b1, 1'b0, "R5 drop held last");
    flit_chk({8'h01, 8'd17}, 1'b1, 1'b1, "R5 new threshold applies next packet");
    model_pkt(1, 0);
    check_stats("R5");

    // R4 non-UDP bypass, statistics untouched
    cmd(OP_SET_THR, 2'd0, 8'd255);
    clear_all();
    flit_chk({8'h00, 8'd6}, 1'b0, 1'b1, "R4 other proto first");
    flit_chk(16'h0011, 1'b1, 1'b1, "R4 other proto last");
    flit_chk({8'h00, 8'd16}, 1'b1, 1'b1, "R4 proto 16");
    flit_chk({8'h00, 8'd18}, 1'b1, 1'b1, "R4 proto 18");
    check_stats("R4");

    // R6 backpressure
    cmd(OP_SET_THR, 2'd0, 8'd128);
    out_ready = 1'b0;
    flit_chk({8'h90, 8'd17}, 1'b0, 1'b1, "R6 first under stall");
    model_pkt(144, 128);
    chk(in_ready == 1'b0, "R6 in_ready low while held", int'(in_ready), 0);
    in_valid = 1'b1; in_data = 16'hBEEF; in_last = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b1, "R6 held valid", int'(out_valid), 1);
    chk(out_data == {8'h90, 8'd17}, "R6 held data", int'(out_data), int'({8'h90, 8'd17}));
    chk(in_ready == 1'b0, "R6 still stalled", int'(in_ready), 0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    chk(out_valid == 1'b1, "R6 next flit valid", int'(out_valid), 1);
    chk(out_data == 16'hBEEF, "R6 next flit data", int'(out_data), 16'hBEEF);
    chk(out_last == 1'b1, "R6 next flit last", int'(out_last), 1);
    @(negedge clk);
    chk(out_valid == 1'b0, "R6 drained", int'(out_valid), 0);
    check_stats("R6");

    // R10 clear collides with an update
    cmd(OP_SET_THR, 2'd0, 8'd0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = OP_CLEAR;
    in_valid = 1'b1; in_data = {8'd50, 8'd17}; in_last = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = OP_NOP; in_valid = 1'b0; in_last = 1'b0;
    chk(out_valid == 1'b1, "R10 packet still forwarded", int'(out_valid), 1);
    m_cnt = 0; m_sum = 0; m_alert = 0;
    check_stats("R10");

    // R9 non-read ops give no response
    cmd(OP_NOP, 2'd1, 8'd0);
    chk(rsp_valid == 1'b0, "R9 no response to no-op", int'(rsp_valid), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule